// File: doc/BRIEF.md
# Shift-and-Add Multiply-Step Functional Unit

This block is an execution unit that sits beside a processor's ALU and speeds up unsigned multiplication. It takes two register-file operands, an accumulator word and an operand word, together with an opcode and an issue strobe. It returns one result word and a one-cycle completion flag.

It offers three operations. The single step conditionally doubles the accumulator and adds the operand, using the accumulator's top bit as the condition. The short multiply runs that step eight times under an internal counter and produces a 16-bit unsigned product of two bytes. The wide multiply forms the full product of two 16-bit halves. The conditional add never uses an enable on the adder. A predicate mask, either all ones or all zeros and taken from the tested bit, is ANDed with the addend.

For the short multiply, the multiplier byte is loaded into the accumulator just above its low byte. Each step tests the top bit of the resulting 16-bit window, most significant bit first. The low 16 bits left after the eighth step are the product.

Top module: `mulstep_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `done` is 0 and `result` is 0.
- R2: Opcode 0 (step) with `acc_in[31]`=1 returns `(acc_in << 1) + opnd_in`, truncated to 32 bits. `done` is 1 in the cycle after issue.
- R3: Opcode 0 (step) with `acc_in[31]`=0 returns `acc_in << 1`, and `opnd_in` has no effect on it. `done` is 1 in the cycle after issue.
- R4: Opcode 1 (byte multiply) returns `acc_in[7:0] * opnd_in[7:0]` in `result[15:0]`, with `result[31:16]` zero. Bits 31:8 of either input have no effect.
- R5: For opcode 1, `done` is 1 in exactly the eighth cycle after the issue cycle and 0 in the seven cycles before it.
- R6: An issue while a byte multiply is running is ignored: `done` and `result` follow the running multiply unchanged.
- R7: Opcode 2 (wide multiply) returns `acc_in[15:0] * opnd_in[15:0]` as a full 32-bit value. Bits 31:16 of either input have no effect. `done` is 1 in the cycle after issue.
- R8: Opcode 3 is ignored: no `done` follows, and `result` keeps its value.
- R9: `done` is high for one cycle per accepted operation, and `result` changes only in a cycle where `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Start strobe, qualifies opcode and operands |
| opcode | input | 2 | 0 step, 1 byte multiply, 2 wide multiply, 3 reserved |
| acc_in | input | 32 | Accumulator operand |
| opnd_in | input | 32 | Addend / multiplicand operand |
| result | output | 32 | Result of the last completed operation |
| done | output | 1 | One-cycle completion flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit accumulator, an 8-step sequence and 16-bit wide-multiply halves. With these values the 16-bit product window sits in the low half of the word, so the bench can observe the masking of the upper half directly. The short iteration count also leaves room to sweep every multiplier byte against sixteen multiplicands spread across the range, including 0 and 255. Issues made during a running sequence, carries out of bit 31 and garbage in the unused operand bits are all reachable with these values.

// File: rtl/mulstep_pkg.sv
package mulstep_pkg;

    localparam int ACC_W_DEF  = 32;
    localparam int SEQ_N_DEF  = 8;
    localparam int HALF_W_DEF = 16;

    typedef enum logic [1:0] {
        OP_STEP  = 2'd0,
        OP_MUL8  = 2'd1,
        OP_MUL16 = 2'd2,
        OP_RSV   = 2'd3
    } op_e;

    typedef struct packed {
        logic busy;
        logic fin;
    } seq_stat_t;

    function automatic int cnt_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/mulstep_lane.sv
module mulstep_lane #(
    parameter int W    = 32,
    parameter int TBIT = 31
) (
    input  logic [W-1:0] acc,
    input  logic [W-1:0] addend,
    output logic [W-1:0] nxt
);
    logic [W-1:0] masked;

    for (genvar i = 0; i < W; i++) begin : g_mask
        assign masked[i] = addend[i] & acc[TBIT];
    end

    assign nxt = (acc << 1) + masked;
endmodule

// File: rtl/mulstep_wide.sv
module mulstep_wide #(
    parameter int ACC_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic [ACC_W-1:0] a,
    input  logic [ACC_W-1:0] b,
    output logic [ACC_W-1:0] prod
);
    logic [ACC_W-1:0] a_z, b_z;

    assign a_z  = ACC_W'(a[HALF_W-1:0]);
    assign b_z  = ACC_W'(b[HALF_W-1:0]);
    assign prod = a_z * b_z;
endmodule

// File: rtl/mulstep_seq.sv
module mulstep_seq
    import mulstep_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int SEQ_N = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [ACC_W-1:0] mplier,
    input  logic [ACC_W-1:0] mcand,
    output seq_stat_t        stat,
    output logic [ACC_W-1:0] acc_next
);
    localparam int CNT_W = cnt_bits(SEQ_N);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SEQ_N - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] mc_q;
    logic             busy_q;

    mulstep_lane #(.W(ACC_W), .TBIT(2*SEQ_N-1)) u_lane (
        .acc    (acc_q),
        .addend (mc_q),
        .nxt    (acc_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= '0;
            mc_q   <= '0;
        end else if (launch) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            acc_q  <= ACC_W'(mplier[SEQ_N-1:0]) << SEQ_N;
            mc_q   <= ACC_W'(mcand[SEQ_N-1:0]);
        end else if (busy_q) begin
            acc_q <= acc_next;
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign stat.busy = busy_q;
    assign stat.fin  = busy_q && (cnt_q == LAST);

    // R5: the step counter rests at zero between sequences
    assert_idle_cnt_R5: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (cnt_q == '0));

    // R6: a launch is never presented while a sequence is running
    assert_no_relaunch_R6: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !launch);
endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit
    import mulstep_pkg::*;
#(
    parameter int ACC_W  = ACC_W_DEF,
    parameter int SEQ_N  = SEQ_N_DEF,
    parameter int HALF_W = HALF_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [1:0]       opcode,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] opnd_in,
    output logic [ACC_W-1:0] result,
    output logic             done
);
    localparam int PROD_W = 2 * SEQ_N;
    localparam logic [ACC_W-1:0] PROD_MASK = ACC_W'((64'd1 << PROD_W) - 64'd1);

    op_e              op;
    logic             accept;
    seq_stat_t        sq;
    logic [ACC_W-1:0] step_res;
    logic [ACC_W-1:0] wide_res;
    logic [ACC_W-1:0] seq_next;
    logic [ACC_W-1:0] result_q;
    logic             done_q;

    assign op     = op_e'(opcode);
    assign accept = issue && !sq.busy;

    mulstep_lane #(.W(ACC_W), .TBIT(ACC_W-1)) u_step (
        .acc    (acc_in),
        .addend (opnd_in),
        .nxt    (step_res)
    );

    mulstep_wide #(.ACC_W(ACC_W), .HALF_W(HALF_W)) u_wide (
        .a    (acc_in),
        .b    (opnd_in),
        .prod (wide_res)
    );

    mulstep_seq #(.ACC_W(ACC_W), .SEQ_N(SEQ_N)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .launch   (accept && (op == OP_MUL8)),
        .mplier   (acc_in),
        .mcand    (opnd_in),
        .stat     (sq),
        .acc_next (seq_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept && op == OP_STEP) begin
                result_q <= step_res;
                done_q   <= 1'b1;
            end else if (accept && op == OP_MUL16) begin
                result_q <= wide_res;
                done_q   <= 1'b1;
            end else if (sq.fin) begin
                result_q <= seq_next & PROD_MASK;
                done_q   <= 1'b1;
            end
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // R3: a step with a clear top bit is a plain doubling
    assert_step_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_STEP && !acc_in[ACC_W-1]) |=>
            (done && result == ($past(acc_in) << 1)));

    // R7: the wide multiply completes one cycle after issue
    assert_wide_next_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_MUL16) |=> done);

    // R8: the reserved opcode produces no completion
    assert_reserved_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_RSV) |=> !done);

    // R4: the upper half of a byte product is always clear
    assert_mul8_upper_R4: assert property (@(posedge clk) disable iff (rst)
        sq.fin |=> (done && ((result >> PROD_W) == '0)));

    // R6: a running sequence ends only with a completion
    assert_busy_to_done_R6: assert property (@(posedge clk) disable iff (rst)
        (sq.busy && !sq.fin) |=> sq.busy);

    // R9: the result moves only together with done
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);
endmodule

// File: tb/mulstep_unit_test.sv
module mulstep_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [1:0]  opcode = 2'd0;
    logic [31:0] acc_in = 32'd0;
    logic [31:0] opnd_in = 32'd0;
    logic [31:0] result;
    logic        done;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state
    int          m_left = 0;
    logic [31:0] m_prod = 32'd0;
    logic [31:0] exp_res = 32'd0;
    logic        exp_done = 1'b0;
    string       tag = "R1";

    always #10 clk = ~clk;

    mulstep_unit uut (
        .clk(clk), .rst(rst), .issue(issue), .opcode(opcode),
        .acc_in(acc_in), .opnd_in(opnd_in), .result(result), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic compare();
        checks++;
        if (done !== exp_done || result !== exp_res) begin
            fails++;
            $display("FAIL %s: done=%0b result=%h expected done=%0b result=%h",
                     tag, done, result, exp_done, exp_res);
        end
    endtask

    // one clock: drive at negedge, advance model, sample at next negedge
    task automatic cyc(input logic iss, input logic [1:0] op,
                       input logic [31:0] a, input logic [31:0] b);
        logic was_busy;
        issue = iss; opcode = op; acc_in = a; opnd_in = b;
        was_busy = (m_left != 0);
        exp_done = 1'b0;
        if (was_busy) begin
            tag = iss ? "R6" : "R5";
            m_left--;
            if (m_left == 0) begin
                exp_done = 1'b1;
                exp_res  = m_prod;
                tag = "R4";
            end
        end else if (iss) begin
            case (op)
                2'd0: begin
                    exp_done = 1'b1;
                    if (a[31]) begin
                        exp_res = (a << 1) + b;
                        tag = "R2";
                    end else begin
                        exp_res = a << 1;
                        tag = "R3";
                    end
                end
                2'd1: begin
                    m_left = 8;
                    m_prod = 32'(a[7:0]) * 32'(b[7:0]);
                    tag = "R5";
                end
                2'd2: begin
                    exp_done = 1'b1;
                    exp_res  = 32'(a[15:0]) * 32'(b[15:0]);
                    tag = "R7";
                end
                default: tag = "R8";
            endcase
        end else begin
            tag = "R9";
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0, 32'd0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        tag = "R1"; compare();
        rst = 1'b0;
        tag = "R1";
        @(negedge clk);
        compare();

        // R2 / R3 step corners
        cyc(1'b1, 2'd0, 32'h8000_0000, 32'hFFFF_FFFF);
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h0000_0001);
        cyc(1'b1, 2'd0, 32'hC000_0001, 32'h8000_0000);
        cyc(1'b1, 2'd0, 32'h7FFF_FFFF, 32'hDEAD_BEEF);
        cyc(1'b1, 2'd0, 32'h0000_0000, 32'hFFFF_FFFF);
        idle(2);

        // R7 wide multiply with garbage upper bits
        cyc(1'b1, 2'd2, 32'hABCD_FFFF, 32'h1234_FFFF);
        cyc(1'b1, 2'd2, 32'h0000_1234, 32'hFFFF_0000);
        cyc(1'b1, 2'd2, 32'h5555_8001, 32'hAAAA_0003);
        idle(1);

        // R8 reserved opcode ignored, result held
        cyc(1'b1, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle(2);

        // R4 / R5 byte multiply corners, upper bits ignored
        cyc(1'b1, 2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle(9);
        cyc(1'b1, 2'd1, 32'h1234_5600, 32'h0000_00FF);
        idle(9);
        cyc(1'b1, 2'd1, 32'h0000_0080, 32'h8765_4301);
        idle(8);
        // R6 issue while busy, including a step and a wide multiply
        cyc(1'b1, 2'd1, 32'h0000_00A5, 32'h0000_003C);
        cyc(1'b1, 2'd0, 32'hFFFF_FFFF, 32'h1111_1111);
        cyc(1'b1, 2'd2, 32'h0000_FFFF, 32'h0000_FFFF);
        cyc(1'b1, 2'd1, 32'h0000_0001, 32'h0000_0001);
        for (int i = 0; i < 6; i++) cyc(1'b1, 2'd0, 32'h8000_0000, 32'h1);
        // immediately after completion a new issue is accepted
        cyc(1'b1, 2'd2, 32'h0000_0002, 32'h0000_0003);
        idle(1);

        // sweep of byte products
        for (int m = 0; m < 256; m++) begin
            for (int k = 0; k < 16; k++) begin
                cyc(1'b1, 2'd1, 32'(m) | 32'hF0F0_0000, 32'(k * 17) | 32'h0F0F_0000);
                idle(8);
            end
        end
        idle(2);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule